// File: doc/BRIEF.md
# Pin I/O Port with Input Inversion and Hardware Blink

This block is a 32-pin general-purpose I/O port controlled through a small word-addressed register bus. Each pin carries four configuration bits: a direction bit, a static drive level, a hardware blink enable and an input inversion bit. From these the port produces the pad output-enable and output-data vectors. Software uses it by writing whole 32-bit words. To change one pin, software reads a register, flips the bit and writes the word back.

Pad inputs are resynchronised through two flip-flops. They are then presented on a read-only input word, after each bit has been XORed with its inversion bit. A free-running prescaler produces one shared blink phase. Every pin in blink mode drives that phase instead of its static level, so all blinking pins toggle together.

Register word offsets: 0x00 direction, 0x04 drive level, 0x08 blink enable, 0x0C input word (read only), 0x10 inversion. Bit n of every register belongs to pin n. Address bits [1:0] are ignored.

Top module: `gpio_port`

## Requirements
- R1: During and after reset, every direction bit is 1 and the drive-level, blink-enable and inversion registers are 0. As a result, `pad_oe` and `pad_out` are all zero and reading offset 0x00 returns 0xFFFFFFFF.
- R2: `pad_oe[n]` is 1 exactly when direction bit n is 0 (0 = output, 1 = input). A direction write takes effect on the clock edge that accepts it.
- R3: A pin whose blink-enable bit is 0 drives its drive-level bit on `pad_out`.
- R4: A pin whose blink-enable bit is 1 drives the shared blink phase. The phase is 0 after reset and inverts on every BLINK_DIV-th rising clock edge counted from reset release, whether or not any pin blinks.
- R5: Reading offset 0x0C returns, for each bit, the `pad_in` value sampled two rising edges earlier XORed with that pin's inversion bit, as the inversion bit stands now.
- R6: Offsets 0x00, 0x04, 0x08 and 0x10 read back the last word written. Each bit is independent, so a read-modify-write of one bit leaves the others unchanged.
- R7: A write to offset 0x0C changes none of the other registers and none of the pad outputs.
- R8: Offsets 0x14, 0x18 and 0x1C read as 0, and writes to them change nothing. `bus_rdata` is 0 whenever no read is in progress (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Pad output enable per pin |
| pad_out | output | 32 | Pad output data per pin |

## Verification
The bench applies several input-word patterns: walking ones, all ones, alternating bits, and a pattern that changes every cycle. Each pattern is applied with inversion cleared and then with a mixed inversion mask. This separates a wrong synchroniser depth or a missing XOR from a correct path, and a per-cycle change exposes a one-cycle latency error. Direction and drive-level words use asymmetric values to expose swapped or merged bits. A blink mask that covers only some output pins, held over several prescaler periods, checks the phase timing and that the override stays local to those pins. Writes to the read-only and unmapped offsets, each followed by read-back of every register, show that those writes have no effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PIN_W  = 32;
    localparam int ADDR_W = 5;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef enum logic [2:0] {
        REG_DIR   = 3'd0,
        REG_LVL   = 3'd1,
        REG_BLINK = 3'd2,
        REG_DIN   = 3'd3,
        REG_INV   = 3'd4
    } reg_idx_e;

    typedef struct packed {
        pin_vec_t dir;
        pin_vec_t lvl;
        pin_vec_t blink;
        pin_vec_t inv;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{dir: '1, lvl: '0, blink: '0, inv: '0};

    function automatic logic [2:0] word_of(input logic [ADDR_W-1:0] addr);
        return addr[ADDR_W-1:2];
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_port_blink.sv
module gpio_port_blink #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic phase,
    output logic wrap
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  pin_vec_t          bus_wdata,
    input  pin_vec_t          din_word,
    output pin_cfg_t          cfg,
    output pin_vec_t          bus_rdata
);
    logic [2:0] word;
    logic       wr_en;
    logic       rd_en;

    assign word  = word_of(bus_addr);
    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            case (word)
                REG_DIR:   cfg.dir   <= bus_wdata;
                REG_LVL:   cfg.lvl   <= bus_wdata;
                REG_BLINK: cfg.blink <= bus_wdata;
                REG_INV:   cfg.inv   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (word)
                REG_DIR:   bus_rdata = cfg.dir;
                REG_LVL:   bus_rdata = cfg.lvl;
                REG_BLINK: bus_rdata = cfg.blink;
                REG_DIN:   bus_rdata = din_word;
                REG_INV:   bus_rdata = cfg.inv;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int BLINK_DIV = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out
);
    pin_cfg_t cfg;
    pin_vec_t pad_sync;
    pin_vec_t din_word;
    logic     blink_phase;
    logic     blink_wrap;

    gpio_port_sync #(.W(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    gpio_port_blink #(.DIV(BLINK_DIV)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink_phase),
        .wrap  (blink_wrap)
    );

    assign din_word = pad_sync ^ cfg.inv;

    gpio_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .din_word  (din_word),
        .cfg       (cfg),
        .bus_rdata (bus_rdata)
    );

    for (genvar n = 0; n < PIN_W; n++) begin : g_pin
        assign pad_oe[n]  = ~cfg.dir[n];
        assign pad_out[n] = cfg.blink[n] ? blink_phase : cfg.lvl[n];
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pad_in,
    input logic [PIN_W-1:0]  pad_oe,
    input logic [PIN_W-1:0]  pad_out,
    input pin_cfg_t          cfg,
    input logic              blink_phase,
    input logic              blink_wrap
);
    logic [1:0] settle;

    always_ff @(posedge clk) begin
        if (rst)              settle <= 2'd0;
        else if (settle != 2'd2) settle <= settle + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_DIR_WRITE_OE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && word_of(bus_addr) == 3'd0) |=> (pad_oe == ~$past(bus_wdata))); // R2

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(blink_wrap) |-> $stable(blink_phase)); // R4

    AST_DIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd2 && bus_sel && !bus_wr && word_of(bus_addr) == 3'd3)
            |-> (bus_rdata == ($past(pad_in, 2) ^ cfg.inv))); // R5

    AST_DIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && word_of(bus_addr) == 3'd3) |=> $stable(cfg)); // R7

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && word_of(bus_addr) > 3'd4) |=> $stable(cfg)); // R8
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .cfg         (cfg),
    .blink_phase (blink_phase),
    .blink_wrap  (blink_wrap)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 6;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;
    string cur_tag = "";

    // behavioural reference state
    logic [31:0] m_dir, m_lvl, m_blk, m_inv, m_s1, m_s2;
    int          m_cnt;
    logic        m_phase;

    gpio_port #(.BLINK_DIV(DIV)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_dir = '1; m_lvl = '0; m_blk = '0; m_inv = '0;
            m_s1 = '0; m_s2 = '0; m_cnt = 0; m_phase = 1'b0;
        end else begin
            if (bus_sel && bus_wr) begin
                case (bus_addr >> 2)
                    0: m_dir = bus_wdata;
                    1: m_lvl = bus_wdata;
                    2: m_blk = bus_wdata;
                    4: m_inv = bus_wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (m_cnt == DIV - 1) begin
                m_cnt = 0;
                m_phase = ~m_phase;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!bus_sel || bus_wr) return '0;
        case (bus_addr >> 2)
            0: return m_dir;
            1: return m_lvl;
            2: return m_blk;
            3: return m_s2 ^ m_inv;
            4: return m_inv;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        string rtag;
        int    w;
        w = int'(bus_addr >> 2);
        if (cur_tag != "") rtag = cur_tag;
        else if (!bus_sel || bus_wr || w > 4) rtag = "R8";
        else if (w == 3) rtag = "R5";
        else rtag = "R6";
        chk((cur_tag != "") ? cur_tag : "R2", "pad_oe", pad_oe, ~m_dir);
        chk((cur_tag != "") ? cur_tag : "R3", "pad_out static", pad_out & ~m_blk, m_lvl & ~m_blk);
        chk((cur_tag != "") ? cur_tag : "R4", "pad_out blink", pad_out & m_blk, m_phase ? m_blk : 32'h0);
        chk(rtag, "bus_rdata", bus_rdata, exp_rdata());
    endtask

    task automatic step(input logic s, input logic w, input logic [4:0] a,
                        input logic [31:0] d, input logic [31:0] p);
        @(negedge clk);
        compare();
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; pad_in = p;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, pad_in);
    endtask

    task automatic rd(input logic [4:0] a);
        step(1'b1, 1'b0, a, '0, pad_in);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        logic [31:0] tmp;
        pats[0] = 32'h0000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hAAAA_AAAA;
        pats[3] = 32'h5555_5555; pats[4] = 32'h8000_0000; pats[5] = 32'h1234_5678;

        // R1: reset state, reading direction while leaving reset
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_tag = "R1";
        rd(5'h00);
        rd(5'h04);
        rd(5'h08);
        rd(5'h10);
        cur_tag = "";

        // R2 / R3 / R6: direction and drive level
        wr(5'h00, 32'h0000_FFFF);
        wr(5'h04, 32'hA5A5_5A5A);
        rd(5'h00);
        rd(5'h04);
        wr(5'h00, 32'hF0F0_0F0F);
        rd(5'h01); // address bits [1:0] ignored

        // R5: input word, inversion off then mixed
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 5'h0C, '0, pats[k]);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 5'h0C, '0, pats[5]);
        wr(5'h10, 32'hF0F0_F0F0);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 5'h0C, '0, pats[5 - k]);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 5'h0C, '0, pats[0]);

        // R4: blink on part of the outputs, over several periods
        wr(5'h00, 32'h0000_0000);
        wr(5'h08, 32'h0000_0FF0);
        for (int k = 0; k < 4 * DIV; k++) step(1'b0, 1'b0, 5'h00, '0, pad_in);
        wr(5'h04, 32'hFFFF_FFFF);
        for (int k = 0; k < 2 * DIV; k++) rd(5'h08);

        // R6: read-modify-write of one bit
        rd(5'h04);
        @(negedge clk);
        tmp = bus_rdata;
        compare();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = tmp ^ 32'h0001_0000;
        rd(5'h04);
        rd(5'h00);

        // R7: write to the input word is ignored
        wr(5'h0C, 32'h1357_9BDF);
        cur_tag = "R7";
        rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h10);
        cur_tag = "";

        // R8: unmapped offsets
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h14, 32'h0);
        rd(5'h14); rd(5'h18); rd(5'h1C);
        rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h10);
        step(1'b0, 1'b1, 5'h00, 32'hDEAD_BEEF, pad_in);

        // R2: everything back to input
        wr(5'h00, 32'hFFFF_FFFF);
        step(1'b0, 1'b0, 5'h00, '0, pad_in);
        step(1'b0, 1'b0, 5'h00, '0, pad_in);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule